// File: doc/BRIEF.md
# Command Completion Event Counter

This block is the per-channel bookkeeping register for completed commands in a DMA channel. The channel engine sends a one-cycle pulse each time a command finishes. Each pulse advances a free-running done count. The host keeps a processed count in the same register word. The number of events still waiting is the difference between the two counts, modulo the counter range.

An interrupt is raised while that difference is nonzero and at least one of two enable bits is set. The host acknowledges by copying the done count it read into the processed field. Because the interrupt follows the difference and is not a sticky flag, any completion that arrives during the acknowledge keeps the counts unequal. A re-read then shows that more events arrived. A mode bit selects between a level interrupt and a one-cycle pulse for each counted event.

There are two host-visible words, chosen by a one-bit address:

- Address 0 is the configuration word.
- Address 1 is the count word.

Writes take effect at the clock edge. Reads are combinational from the current state.

Top module: `cmd_done_tracker`

## Requirements
- R1: After reset, the configuration word reads 0, the count word reads 0, and `irq` is 0.
- R2: Each cycle with `evt_pulse` high increments the done count (count word bits [5:0]) by one, wrapping from 63 to 0.
- R3: A write to the count word loads the processed count (bits [21:16]) from write-data bits [21:16]. Write-data bits [5:0] and bit 8 have no effect: the done count is unchanged by the write.
- R4: Count-word bit 8 reads 1 exactly when done ≠ processed and configuration bit 29 or bit 31 is 1. Otherwise it reads 0.
- R5: With configuration bit 28 = 1 (level mode), `irq` equals count-word bit 8, taken after the same clock edge.
- R6: When an event pulse and a count-word write occur in the same cycle, the event is counted and the processed count takes the written value. Acknowledging the previous done value in that cycle therefore leaves bit 8 and a level `irq` asserted.
- R7: With configuration bits 29 and 31 both 0, `irq` and bit 8 stay 0 even while events are pending.
- R8: With bit 28 = 0 (pulse mode) and an enable set, `irq` is high for exactly the one cycle following each counted event. It is low in any cycle not preceded by an event.
- R9: Configuration bits 31, 29 and 28 read back as last written. All other configuration bits read 0.
- R10: Pending events are counted modulo 64, so exactly 64 unacknowledged events make the counts equal again and clear bit 8 and a level `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 1 | One-cycle command-completed pulse from the channel engine |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 configuration, 1 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Channel interrupt |

## Verification
The bench drives the done count through a full wrap while nothing is acknowledged. A design that kept a sticky flag, or counted with a different width, would keep the interrupt set once 64 events alias to equal counts.

It sweeps every processed value against a fixed done value to check the difference decode. A wrong subtraction or comparison would raise the active bit at the wrong values.

It collides an event with the acknowledge write. A design that let the write win would lose a completion and drop the interrupt.

It also writes garbage into the done field. It then checks pulse-mode width and the enable gating, because a leaky write path or a stretched pulse shows directly at the ports.

// File: rtl/evtcnt_pkg.sv
// Package: shared field positions and config type for the completion counter.
// Assumes count fields are at most 8 bits wide so they fit their slots.
package evtcnt_pkg;
    localparam int DONE_LSB = 0;
    localparam int ACT_BIT  = 8;
    localparam int PROC_LSB = 16;
    localparam int LEVEL_BIT = 28;
    localparam int IEN_BIT   = 29;
    localparam int LIEN_BIT  = 31;
    localparam int WORD_W    = 32;

    typedef struct packed {
        logic list_ien;
        logic ien;
        logic level;
    } irq_cfg_t;
endpackage

// File: rtl/evtcnt_done_ctr.sv
// Module: free-running done counter advanced only by engine event pulses.
// Assumes evt_i is a single-cycle pulse per completed command.
module evtcnt_done_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    output logic [CNT_W-1:0] done_o
);
    // Count events modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= '0;
        else if (evt_i)
            done_o <= done_o + CNT_W'(1);
    end

    p_done_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> done_o == CNT_W'($past(done_o) + CNT_W'(1)));

    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(done_o));
endmodule

// File: rtl/evtcnt_ack_reg.sv
// Module: host-written processed count register.
// Assumes the host writes the done value it observed to acknowledge.
module evtcnt_ack_reg #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_we_i,
    input  logic [CNT_W-1:0] ack_val_i,
    output logic [CNT_W-1:0] proc_o
);
    // Load the processed count on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            proc_o <= '0;
        else if (ack_we_i)
            proc_o <= ack_val_i;
    end

    p_ack_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> proc_o == $past(ack_val_i));

    p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we_i |=> $stable(proc_o));
endmodule

// File: rtl/evtcnt_irq.sv
// Module: pending-difference decode and interrupt generation.
// Assumes done/proc are registered. Level mode follows the difference;
// pulse mode emits one cycle per counted event.
module evtcnt_irq #(
    parameter int CNT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   evt_i,
    input  logic [CNT_W-1:0]       done_i,
    input  logic [CNT_W-1:0]       proc_i,
    input  evtcnt_pkg::irq_cfg_t   cfg_i,
    output logic                   active_o,
    output logic                   irq_o
);
    logic [CNT_W-1:0] pend;
    logic             en;
    logic             pulse_q;

    // Pending events and enable gating.
    always_comb begin
        pend     = done_i - proc_i;
        en       = cfg_i.ien | cfg_i.list_ien;
        active_o = en && (pend != '0);
    end

    // One-cycle pulse after each enabled event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= evt_i & en;
    end

    // Select the interrupt flavour.
    always_comb begin
        irq_o = cfg_i.level ? active_o : pulse_q;
    end

    p_equal_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i == proc_i) |-> !active_o);

    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.level && !active_o) |-> !irq_o);

    p_gated_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.ien && !cfg_i.list_ien) |-> (!active_o && !pulse_q));

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.level && irq_o) |-> $past(evt_i));
endmodule

// File: rtl/cmd_done_tracker.sv
// Module: per-channel completion counter register block (top).
// Word 0 is the interrupt configuration, word 1 holds done/active/processed.
// Assumes CNT_W <= 8 so the count fields fit their bit slots.
module cmd_done_tracker #(
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_pulse,
    input  logic        reg_wr_en,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
    ,
    output logic        irq
);
    import evtcnt_pkg::*;

    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] proc_cnt;
    irq_cfg_t         cfg_q;
    logic             int_active;
    logic             cfg_we;
    logic             cnt_we;
    logic             wdata_unused;
    logic [31:0]      cfg_word;
    logic [31:0]      cnt_word;

    // Write decode.
    always_comb begin
        cfg_we       = reg_wr_en && !reg_addr;
        cnt_we       = reg_wr_en && reg_addr;
        wdata_unused = ^reg_wdata;
    end

    // Configuration register: only the three interrupt bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= '{list_ien: reg_wdata[LIEN_BIT],
                       ien:      reg_wdata[IEN_BIT],
                       level:    reg_wdata[LEVEL_BIT]};
    end

    evtcnt_done_ctr #(.CNT_W(CNT_W)) i_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .done_o (done_cnt)
    );

    evtcnt_ack_reg #(.CNT_W(CNT_W)) i_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_we_i  (cnt_we),
        .ack_val_i (reg_wdata[PROC_LSB +: CNT_W]),
        .proc_o    (proc_cnt)
    );

    evtcnt_irq #(.CNT_W(CNT_W)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_pulse),
        .done_i   (done_cnt),
        .proc_i   (proc_cnt),
        .cfg_i    (cfg_q),
        .active_o (int_active),
        .irq_o    (irq)
    );

    // Assemble both readable words.
    always_comb begin
        cfg_word            = '0;
        cfg_word[LIEN_BIT]  = cfg_q.list_ien;
        cfg_word[IEN_BIT]   = cfg_q.ien;
        cfg_word[LEVEL_BIT] = cfg_q.level;
        cnt_word                      = '0;
        cnt_word[DONE_LSB +: CNT_W]   = done_cnt;
        cnt_word[ACT_BIT]             = int_active;
        cnt_word[PROC_LSB +: CNT_W]   = proc_cnt;
    end

    // Read mux.
    always_comb begin
        reg_rdata = reg_addr ? cnt_word : cfg_word;
    end

    p_cfg_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_word == ($past(reg_wdata) & 32'hB000_0000)));

    p_collide_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse && cnt_we && (cfg_q.ien || cfg_q.list_ien) && !cfg_we &&
         reg_wdata[PROC_LSB +: CNT_W] == done_cnt) |=> int_active);
endmodule

// File: tb/test_cmd_done_tracker.sv
module test_cmd_done_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pulse = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] e_done = '0;
    logic [5:0] e_proc = '0;
    logic [31:0] e_cfg = '0;

    always #2.5 clk = ~clk;

    cmd_done_tracker i_cmd_done_tracker (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_act();
        return (e_done != e_proc) && (e_cfg[29] || e_cfg[31]);
    endfunction

    function automatic logic [31:0] exp_cnt();
        logic [31:0] w = '0;
        w[5:0] = e_done;
        w[8] = exp_act();
        w[21:16] = e_proc;
        return w;
    endfunction

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
        if (a) e_proc = d[21:16]; else e_cfg = d & 32'hB000_0000;
    endtask

    task automatic evt();
        evt_pulse = 1'b1;
        @(negedge clk);
        evt_pulse = 1'b0;
        e_done = e_done + 6'd1;
    endtask

    task automatic rd_cnt(input string tag);
        reg_addr = 1'b1; #1;
        chk(tag, reg_rdata, exp_cnt());
    endtask

    initial begin
        #(5 * 20000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_addr = 1'b0; #1; chk("R1 cfg", reg_rdata, 32'h0);
        rd_cnt("R1 cnt");
        chk("R1 irq", {31'b0, irq}, 32'h0);
        // R9 config readback
        wr(1'b0, 32'hFFFF_FFFF);
        reg_addr = 1'b0; #1; chk("R9 all ones", reg_rdata, 32'hB000_0000);
        wr(1'b0, 32'h4FFF_FFFF);
        reg_addr = 1'b0; #1; chk("R9 none", reg_rdata, 32'h0);
        // level + ien
        wr(1'b0, 32'h3000_0000);
        // R2 R5 R10 sweep through wrap without ack
        for (int i = 0; i < 70; i++) begin
            evt();
            rd_cnt(e_done == 6'd0 ? "R10 wrap equal" : "R2 count");
            chk("R5 level irq", {31'b0, irq}, {31'b0, exp_act()});
        end
        // R3 ack with garbage in done field and bit 8
        begin
            logic [31:0] d;
            d = '0; d[21:16] = e_done; d[5:0] = ~e_done; d[8] = 1'b1;
            wr(1'b1, d);
            rd_cnt("R3 ack done unchanged");
            chk("R3 irq cleared", {31'b0, irq}, 32'h0);
        end
        // R4 sweep processed values
        for (int p = 0; p < 64; p++) begin
            logic [31:0] d;
            d = '0; d[21:16] = 6'(p);
            wr(1'b1, d);
            rd_cnt("R4 decode");
            chk("R4 R5 irq", {31'b0, irq}, {31'b0, exp_act()});
        end
        // R6 event colliding with ack of current done
        begin
            logic [31:0] d;
            d = '0; d[21:16] = e_done;
            reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wdata = d; evt_pulse = 1'b1;
            @(negedge clk);
            reg_wr_en = 1'b0; evt_pulse = 1'b0; reg_wdata = '0;
            e_proc = d[21:16]; e_done = e_done + 6'd1;
            rd_cnt("R6 collide count");
            chk("R6 irq kept", {31'b0, irq}, 32'h1);
        end
        // R7 enables off with pending
        wr(1'b0, 32'h1000_0000);
        rd_cnt("R7 bit8 off");
        chk("R7 irq off", {31'b0, irq}, 32'h0);
        evt();
        chk("R7 irq off after evt", {31'b0, irq}, 32'h0);
        wr(1'b0, 32'h9000_0000);
        rd_cnt("R4 list enable");
        chk("R5 list enable irq", {31'b0, irq}, 32'h1);
        // R8 pulse mode
        wr(1'b0, 32'h2000_0000);
        chk("R8 idle low", {31'b0, irq}, 32'h0);
        evt();
        chk("R8 pulse high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, irq}, 32'h0);
        evt(); evt();
        chk("R8 back to back", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R8 back to back end", {31'b0, irq}, 32'h0);
        rd_cnt("R8 count word");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule